// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Deferred Shutdown

This block turns parallel characters into asynchronous serial frames on a single output line. Software, or a neighbouring block, places one character at a time into a one-entry holding register. When the shifter is free, the character moves into the shifter at a bit-rate tick, and the frame goes out one bit per tick. A frame has a low start bit, 5 to 9 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The bit rate comes from outside as a one-cycle strobe per bit period.

The block drives an output-enable alongside the line, so it can release a shared wire. When the enable input is dropped, the block keeps running until everything already accepted has gone out, and only then releases the pin. A completion flag marks the moment the last stop bit ends with nothing left to send, which is when a half-duplex node can turn its bus around. The flag can raise an interrupt. It clears itself when that interrupt is acknowledged, and it can also be cleared by a write-one-to-clear pulse.

Top module: `uart_tx_core`

## Requirements
- R1: The line idles at 1. A frame is a start bit of 0, then the data bits with the least significant bit first, then the stop bits at 1. The line changes only on a cycle after `baud_tick` was high, so each bit lasts exactly one tick interval.
- R2: `char_bits` sets the data width. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. Data bit 8 is taken from `wr_bit8`, and bits 0..7 come from `wr_data`.
- R3: When `par_mode[1]` is 1, a parity bit follows the last data bit. `par_mode[0]` = 0 gives even parity and 1 gives odd parity, computed over the active data bits only. When `par_mode[1]` is 0, no parity bit is sent.
- R4: `two_stop` = 1 sends two stop bits and 0 sends one. Format inputs are taken when a character enters the shifter.
- R5: `buf_empty` is 1 whenever the holding register can take a character. A write (`wr_valid` high) is accepted only while `txd_oe` is 1 and the register is empty. A write at any other time changes neither the register nor the line.
- R6: A held character enters the shifter at the first `baud_tick` on which the shifter is idle or is ending its last stop bit. The holding register becomes free at that same edge, so consecutive frames follow with no idle gap.
- R7: `txd_oe` rises on the cycle after `tx_en` is seen high. After `tx_en` falls, `txd_oe` stays high while a frame is in flight or a character is held, and falls one cycle after both are empty.
- R8: While `txd_oe` is 0, `txd` is 1.
- R9: `txc_flag` rises on the cycle after the tick that ends a frame's last stop bit, if no character is held at that tick. `txc_irq` equals `txc_flag` AND `txc_ie`.
- R10: A high `txc_ack` or `txc_clr` clears `txc_flag` on the next cycle. A completion in the same cycle wins over the clear.
- R11: After synchronous reset, `txd` is 1, `txd_oe` is 0, `buf_empty` is 1 and `txc_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| tx_en | input | 1 | Transmit enable request |
| par_mode | input | 2 | Bit 1 enables parity, bit 0 selects odd parity |
| two_stop | input | 1 | 1 selects two stop bits |
| char_bits | input | 4 | Data bits per character, 5 to 9 |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character bits 0..7 |
| wr_bit8 | input | 1 | Character bit 8, used for 9-bit characters |
| txc_ie | input | 1 | Completion interrupt enable |
| txc_ack | input | 1 | Completion interrupt acknowledge |
| txc_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | High while the block drives the line |
| buf_empty | output | 1 | Holding register can accept a write |
| txc_flag | output | 1 | Transmission complete flag |
| txc_irq | output | 1 | Completion interrupt request |

## Verification
A wrong bit counter or a wrong frame image shows up on `txd` within one tick interval of the bad bit: a stop bit that comes too early, a missing parity bit, or a start bit where a data bit belongs. A wrong holding-register state shows up at `buf_empty` on the next cycle. It also shows up on the line as a repeated or lost frame at the next tick. An error in the enable or completion logic appears one cycle after the frame's final tick, as `txd_oe` falling early or late or `txc_flag` changing at the wrong time. A behavioural reference model compares all five outputs on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned FRAME_W  = MAX_BITS + 4;
  localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

  typedef logic [MAX_BITS-1:0] char_t;
  typedef logic [FRAME_W-1:0]  frame_t;
  typedef logic [LEN_W-1:0]    len_t;

  typedef struct packed {
    logic       par_on;
    logic       par_odd;
    logic       two_stop;
    logic [3:0] nbits;
  } fmt_t;

  // Line image, bit 0 leaves first; unused upper bits are stop-level ones.
  function automatic frame_t build_frame(char_t d, fmt_t f);
    frame_t r;
    logic   p;
    r    = '1;
    r[0] = 1'b0;
    p    = f.par_odd;
    for (int i = 0; i < int'(MAX_BITS); i++) begin
      if (i < int'(f.nbits)) begin
        r[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    for (int i = 0; i <= int'(MAX_BITS); i++) begin
      if (f.par_on && (i == int'(f.nbits))) r[i+1] = p;
    end
    return r;
  endfunction

  function automatic len_t frame_len(fmt_t f);
    return len_t'(32'd1 + 32'(f.nbits) + 32'(f.par_on) + (f.two_stop ? 32'd2 : 32'd1));
  endfunction

endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic         wr_allow,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data,
  output logic         wr_acc
);

  assign wr_acc = wr_valid & wr_allow & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (wr_acc) begin
        full <= 1'b1;
        data <= wr_data;
      end
    end
  end

  // R5
  write_when_full_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_valid && !take) |=> (full && $stable(data)));

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int FW = 13,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          avail,
  input  logic [FW-1:0] frame_in,
  input  logic [LW-1:0] len_in,
  output logic          txd,
  output logic          busy,
  output logic          take,
  output logic          done
);

  logic [FW-1:0] sh;
  logic [LW-1:0] left;
  logic          last;
  logic          slot;

  assign last = busy && (left == LW'(1));
  assign slot = en && tick && (!busy || last);
  assign take = slot && avail;
  assign done = slot && busy && !avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (en && tick) begin
      if (busy && !last) begin
        sh   <= {1'b1, sh[FW-1:1]};
        txd  <= sh[1];
        left <= left - LW'(1);
      end else if (avail) begin
        sh   <= frame_in;
        txd  <= frame_in[0];
        left <= len_in;
        busy <= 1'b1;
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R1
  change_on_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  // R6
  start_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (busy && !txd));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic busy,
  input  logic full,
  input  logic wr_acc,
  input  logic done,
  input  logic ack,
  input  logic clr,
  input  logic ie,
  output logic en,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      en <= tx_en | (en & (busy | full | wr_acc));
      if (done)            flag <= 1'b1;
      else if (ack | clr)  flag <= 1'b0;
    end
  end

  assign irq = flag & ie;

  // R7
  hold_enable_while_work_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !tx_en && (busy || full)) |=> en);

  // R7
  stay_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !tx_en) |=> !en);

  // R9
  flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> flag);

  // R10
  flag_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && (ack || clr) && !done) |=> !flag);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic [1:0] par_mode,
  input  logic       two_stop,
  input  logic [3:0] char_bits,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_bit8,
  input  logic       txc_ie,
  input  logic       txc_ack,
  input  logic       txc_clr,
  output logic       txd,
  output logic       txd_oe,
  output logic       buf_empty,
  output logic       txc_flag,
  output logic       txc_irq
);

  fmt_t   fmt;
  char_t  held;
  frame_t frame;
  len_t   flen;
  logic   full, wr_acc, take, done, busy;

  always_comb begin
    fmt.par_on   = par_mode[1];
    fmt.par_odd  = par_mode[0];
    fmt.two_stop = two_stop;
    if (char_bits < 4'(MIN_BITS))      fmt.nbits = 4'(MIN_BITS);
    else if (char_bits > 4'(MAX_BITS)) fmt.nbits = 4'(MAX_BITS);
    else                               fmt.nbits = char_bits;
  end

  assign frame     = build_frame(held, fmt);
  assign flen      = frame_len(fmt);
  assign buf_empty = ~full;

  uart_tx_buf #(.W(MAX_BITS)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_allow (txd_oe),
    .wr_data  ({wr_bit8, wr_data}),
    .take     (take),
    .full     (full),
    .data     (held),
    .wr_acc   (wr_acc)
  );

  uart_tx_shift #(.FW(FRAME_W), .LW(LEN_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .en       (txd_oe),
    .tick     (baud_tick),
    .avail    (full),
    .frame_in (frame),
    .len_in   (flen),
    .txd      (txd),
    .busy     (busy),
    .take     (take),
    .done     (done)
  );

  uart_tx_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .busy   (busy),
    .full   (full),
    .wr_acc (wr_acc),
    .done   (done),
    .ack    (txc_ack),
    .clr    (txc_clr),
    .ie     (txc_ie),
    .en     (txd_oe),
    .flag   (txc_flag),
    .irq    (txc_irq)
  );

  // R8
  released_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !txd_oe |-> txd);

  // R9
  flag_rise_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txc_flag) |-> !busy);

endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       two_stop = 1'b0;
  logic [3:0] char_bits = 4'd8;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit8 = 1'b0;
  logic       txc_ie = 1'b0;
  logic       txc_ack = 1'b0;
  logic       txc_clr = 1'b0;
  logic       txd, txd_oe, buf_empty, txc_flag, txc_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int tick_cnt = 0;
  int tick_div = 4;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  uart_tx_core u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
    .par_mode(par_mode), .two_stop(two_stop), .char_bits(char_bits),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit8(wr_bit8),
    .txc_ie(txc_ie), .txc_ack(txc_ack), .txc_clr(txc_clr),
    .txd(txd), .txd_oe(txd_oe), .buf_empty(buf_empty),
    .txc_flag(txc_flag), .txc_irq(txc_irq)
  );

  // ---------------- reference model ----------------
  bit       m_en, m_full, m_active, m_txd, m_txc;
  bit [8:0] m_buf;
  bit       m_q[$];
  bit       p_en, p_full, p_act, m_acc, m_set;

  task automatic m_load(bit [8:0] d);
    int nb;
    bit p;
    nb = int'(char_bits);
    if (nb < 5) nb = 5;
    if (nb > 9) nb = 9;
    m_q.delete();
    m_q.push_back(1'b0);
    p = par_mode[0];
    for (int i = 0; i < nb; i++) begin
      m_q.push_back(d[i]);
      p = p ^ d[i];
    end
    if (par_mode[1]) m_q.push_back(p);
    m_q.push_back(1'b1);
    if (two_stop) m_q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_full = 0; m_active = 0; m_txd = 1; m_txc = 0;
      m_buf = '0; m_q.delete();
    end else begin
      p_en = m_en; p_full = m_full; p_act = m_active;
      m_acc = wr_valid && p_en && !p_full;
      m_set = 0;
      if (p_en && baud_tick) begin
        if (m_q.size() > 0) m_txd = m_q.pop_front();
        else if (p_full) begin
          m_load(m_buf);
          m_active = 1; m_full = 0;
          m_txd = m_q.pop_front();
        end else begin
          if (p_act) m_set = 1;
          m_active = 0; m_txd = 1;
        end
      end
      if (m_acc) begin m_full = 1; m_buf = {wr_bit8, wr_data}; end
      m_en = tx_en || (p_en && (p_act || p_full || m_acc));
      if (m_set) m_txc = 1;
      else if (txc_ack || txc_clr) m_txc = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(txd == m_txd, "R1 R2 R3 R4 R5 R6 R8 txd", int'(txd), int'(m_txd));
      check(txd_oe == m_en, "R7 txd_oe", int'(txd_oe), int'(m_en));
      check(buf_empty == !m_full, "R5 buf_empty", int'(buf_empty), int'(!m_full));
      check(txc_flag == m_txc, "R9 R10 txc_flag", int'(txc_flag), int'(m_txc));
      check(txc_irq == (m_txc && txc_ie), "R9 txc_irq", int'(txc_irq), int'(m_txc && txc_ie));
    end
  end

  always @(posedge clk) begin
    #1;
    tick_cnt++;
    baud_tick = (tick_cnt % tick_div) == 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(bit [8:0] d);
    wr_valid = 1; wr_data = d[7:0]; wr_bit8 = d[8];
    cyc(1);
    wr_valid = 0;
  endtask

  task automatic wait_free();
    for (int k = 0; k < 3000; k++) begin
      if (m_full == 0) break;
      cyc(1);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      if (!m_full && !m_active) break;
      cyc(1);
    end
    cyc(tick_div + 2);
  endtask

  task automatic pulse_ack(bit use_clr);
    if (use_clr) txc_clr = 1; else txc_ack = 1;
    cyc(1);
    txc_clr = 0; txc_ack = 0;
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    // R11 reset state
    check(txd == 1, "R11 txd", int'(txd), 1);
    check(txd_oe == 0, "R11 txd_oe", int'(txd_oe), 0);
    check(buf_empty == 1, "R11 buf_empty", int'(buf_empty), 1);
    check(txc_flag == 0, "R11 txc_flag", int'(txc_flag), 0);
    cyc(1);

    // R5: write while disabled is ignored
    wr(9'h0A5);
    @(negedge clk);
    check(buf_empty == 1, "R5 disabled write", int'(buf_empty), 1);
    check(txd_oe == 0, "R8 released", int'(txd_oe), 0);
    cyc(2);

    // R7: enable
    tx_en = 1;
    cyc(1);
    @(negedge clk);
    check(txd_oe == 1, "R7 enable", int'(txd_oe), 1);
    cyc(1);

    // R1 8N1 frame and completion
    char_bits = 4'd8; par_mode = 2'b00; two_stop = 0;
    wr(9'h053);
    wait_idle();
    @(negedge clk);
    check(txc_flag == 1, "R9 flag after frame", int'(txc_flag), 1);
    txc_ie = 1;
    #1;
    check(txc_irq == 1, "R9 irq", int'(txc_irq), 1);
    cyc(1);
    pulse_ack(0);
    @(negedge clk);
    check(txc_flag == 0, "R10 ack clears", int'(txc_flag), 0);
    cyc(1);

    // R2 R3 R4 R6: formats with back-to-back pairs
    for (int s = 3; s <= 12; s++) begin
      char_bits = 4'(s);
      par_mode  = 2'(s % 4);
      two_stop  = s[0];
      wr(9'(s * 37 + 5));
      wait_free();
      wr(9'(9'h1C3 ^ 9'(s * 11)));
      wait_free();
      wr(9'h0FF);  // may land while full; model covers R5
      wr(9'h100);
      wait_idle();
      @(negedge clk);
      check(txc_flag == 1, "R9 flag after burst", int'(txc_flag), 1);
      cyc(1);
      pulse_ack(1);
      @(negedge clk);
      check(txc_flag == 0, "R10 clr clears", int'(txc_flag), 0);
      cyc(1);
    end

    // R7 deferred disable with a frame in flight and one held
    char_bits = 4'd7; par_mode = 2'b11; two_stop = 1;
    wr(9'h05A);
    wait_free();
    wr(9'h033);
    tx_en = 0;
    cyc(8);
    @(negedge clk);
    check(txd_oe == 1, "R7 deferred", int'(txd_oe), 1);
    wait_idle();
    @(negedge clk);
    check(txd_oe == 0, "R7 released after work", int'(txd_oe), 0);
    check(txd == 1, "R8 idle level", int'(txd), 1);
    cyc(1);

    // random phase
    tick_div = 3;
    for (int k = 0; k < 4000; k++) begin
      tx_en    = ($urandom % 8) != 0;
      wr_valid = ($urandom % 4) == 0;
      wr_data  = 8'($urandom);
      wr_bit8  = 1'($urandom);
      txc_ack  = ($urandom % 16) == 0;
      txc_clr  = ($urandom % 16) == 1;
      txc_ie   = 1'($urandom);
      if (($urandom % 64) == 0) begin
        char_bits = 4'($urandom % 16);
        par_mode  = 2'($urandom);
        two_stop  = 1'($urandom);
      end
      cyc(1);
    end
    wr_valid = 0; txc_ack = 0; txc_clr = 0;
    cyc(60);

    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule